// File: doc/BRIEF.md
# Multi-Mode Pin Bank

This block sits between a microcontroller bus and a bank of 27 general pins grouped into four ports. Each pin is configured on its own to act as a plain software-controlled I/O bit, as an input and output of on-chip programmable logic, as a latched low-address output for a processor with a multiplexed address/data bus, or as one bit of a 16-bit data bus for a processor with a separate address bus. Only the first two ports can form the data bus.

Software reaches four registers per port through a small synchronous register interface. The registers are an output-value register, a direction register and two mode bit-planes. Pads are modelled as split signals: the level seen on the pin, the value to drive, and an output enable. The tri-state buffer itself belongs to the pad ring.

Top module: `iop_bank`

## Requirements
- R1: Pin numbering is fixed: port A holds pins 0–7, port B pins 8–15, port C pins 16–23 and port D pins 24–26. There are 27 pins in all.
- R2: While reset is low and at the first clock after it, every pin is in software I/O mode with direction input. All output-value bits are 0, the address latch holds 0, and every `pin_oe` bit is 0.
- R3: `reg_addr[3:2]` selects the port (0=A, 1=B, 2=C, 3=D) and `reg_addr[1:0]` selects the register: 0 output value, 1 direction, 2 mode plane 0, 3 mode plane 1. A write with `reg_we` high takes effect at the clock edge. For a port narrower than 8 bits, data bits above its width are ignored and read back as 0. For kinds 1–3, `reg_rdata` returns the stored register without waiting for a clock.
- R4: A pin's mode is {plane1[i], plane0[i]}, where 0 is software I/O, 1 is logic I/O, 2 is latched address and 3 is data port. Writing a plane changes only the pins whose bits change.
- R5: In software I/O mode, `pin_oe` follows the direction bit (1 = output) and `pin_o` follows the output-value bit.
- R6: A read of kind 0 returns, for each bit, the output-value bit if the pin is an output and the live `pin_i` level if it is an input.
- R7: In logic mode, `pin_o`/`pin_oe` follow `pld_out`/`pld_oe` of the same pin. `pld_in` always mirrors `pin_i` for every pin, in any mode.
- R8: The address latch loads `addr_i` at a clock edge where `ale` is sampled low after being sampled high at the edge before. At all other edges it holds its value. A pin in latched-address mode always drives: bit i of ports A and C shows latched bit i, and bit i of ports B and D shows latched bit 8+i.
- R9: In data-port mode, a pin of port A (bit i) or port B (bit i) drives `bus_rdata[i]` or `bus_rdata[8+i]` only while `bus_rd` is high, and floats otherwise. `bus_wdata` always equals {port B pin levels, port A pin levels}.
- R10: On ports C and D, mode 3 behaves exactly like software I/O mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Port and register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ale | input | 1 | Address latch strobe |
| addr_i | input | 16 | Address to be latched |
| bus_rd | input | 1 | Processor read cycle active (data-port mode) |
| bus_rdata | input | 16 | Data placed on ports A/B during a read |
| bus_wdata | output | 16 | Pin levels of ports B and A |
| pld_out | input | 27 | Logic-mode drive values |
| pld_oe | input | 27 | Logic-mode output enables |
| pld_in | output | 27 | Pin levels forwarded to the logic |
| pin_i | input | 27 | Level seen at each pin |
| pin_o | output | 27 | Value to drive on each pin |
| pin_oe | output | 27 | Output enable of each pin |

## Verification
The pin outputs, `reg_rdata`, `pld_in` and `bus_wdata` are combinational from the stored state and the current inputs, so changes to `pin_i`, `bus_rd`, `bus_rdata` or `pld_*` show in the same cycle. A register write or a falling `ale` shows one edge later, because one register stands between the strobe and the pins. The bench drives inputs on the falling clock edge. Its reference model updates on the rising edge, and the comparison runs 2 ns after each falling edge, once both the new state and the new inputs have settled.

// File: rtl/iop_pkg.sv
package iop_pkg;

  typedef enum logic [1:0] {
    PM_SW    = 2'd0,
    PM_LOGIC = 2'd1,
    PM_ADDR  = 2'd2,
    PM_DPORT = 2'd3
  } pin_mode_e;

  // Live read value of one pin: stored value if driven, pad level if not.
  function automatic logic live_bit(input logic is_out, input logic stored, input logic pad);
    return is_out ? stored : pad;
  endfunction

  // Which latched address bit a pin shows: odd ports take the upper half.
  function automatic int latch_index(input int port, input int idx, input int aw);
    return (port % 2) * (aw / 2) + idx;
  endfunction

endpackage

// File: rtl/iop_port_regs.sv
module iop_port_regs #(
  parameter int W       = 8,
  parameter int DW      = 8,
  parameter int PORT_ID = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel_port,
  input  logic [1:0]    sel_kind,
  input  logic [DW-1:0] wdata,
  input  logic [W-1:0]  pad,
  output logic [DW-1:0] rdata,
  output logic [W-1:0]  dout_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  plane0_q,
  output logic [W-1:0]  plane1_q
);
  import iop_pkg::*;

  logic hit;
  assign hit = we && (sel_port == 2'(PORT_ID));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q   <= '0;
      dir_q    <= '0;
      plane0_q <= '0;
      plane1_q <= '0;
    end else if (hit) begin
      case (sel_kind)
        2'd0:    dout_q   <= wdata[W-1:0];
        2'd1:    dir_q    <= wdata[W-1:0];
        2'd2:    plane0_q <= wdata[W-1:0];
        default: plane1_q <= wdata[W-1:0];
      endcase
    end
  end

  logic [W-1:0] view;
  always_comb begin
    view = '0;
    case (sel_kind)
      2'd0: for (int i = 0; i < W; i++) view[i] = live_bit(dir_q[i], dout_q[i], pad[i]);
      2'd1: view = dir_q;
      2'd2: view = plane0_q;
      default: view = plane1_q;
    endcase
    rdata = '0;
    rdata[W-1:0] = view;
  end

  // R3: a direction write lands one edge later
  a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sel_kind == 2'd1) |=> dir_q == $past(wdata[W-1:0]));
  // R2: state is clear on the first edge out of reset
  a_r2_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir_q == '0 && dout_q == '0 && plane0_q == '0 && plane1_q == '0));

endmodule

// File: rtl/iop_addr_latch.sv
module iop_addr_latch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_q,
  output logic          ale_fall
);
  logic ale_q;

  assign ale_fall = ale_q && !ale;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      ale_q <= ale;
      if (ale_fall) addr_q <= addr_i;
    end
  end

  // R8: capture on the falling strobe
  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ale_fall |=> addr_q == $past(addr_i));
  // R8: hold between strobes
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_fall |=> $stable(addr_q));

endmodule

// File: rtl/iop_pin_cell.sv
module iop_pin_cell #(
  parameter bit HAS_DPORT = 1'b0
) (
  input  logic [1:0] mode,
  input  logic       sw_dout,
  input  logic       sw_dir,
  input  logic       lg_out,
  input  logic       lg_oe,
  input  logic       addr_b,
  input  logic       bus_rd,
  input  logic       bus_b,
  output logic       pin_o,
  output logic       pin_oe
);
  import iop_pkg::*;

  always_comb begin
    pin_o  = sw_dout;
    pin_oe = sw_dir;
    case (pin_mode_e'(mode))
      PM_LOGIC: begin
        pin_o  = lg_out;
        pin_oe = lg_oe;
      end
      PM_ADDR: begin
        pin_o  = addr_b;
        pin_oe = 1'b1;
      end
      PM_DPORT: begin
        if (HAS_DPORT) begin
          pin_o  = bus_b;
          pin_oe = bus_rd;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/iop_bank.sv
module iop_bank #(
  parameter int W_A = 8,
  parameter int W_B = 8,
  parameter int W_C = 8,
  parameter int W_D = 3,
  parameter int AW  = 16,
  parameter int DW  = 8,
  localparam int NPIN  = W_A + W_B + W_C + W_D,
  localparam int BUS_W = W_A + W_B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             ale,
  input  logic [AW-1:0]    addr_i,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_rdata,
  output logic [BUS_W-1:0] bus_wdata,
  input  logic [NPIN-1:0]  pld_out,
  input  logic [NPIN-1:0]  pld_oe,
  output logic [NPIN-1:0]  pld_in,
  input  logic [NPIN-1:0]  pin_i,
  output logic [NPIN-1:0]  pin_o,
  output logic [NPIN-1:0]  pin_oe
);
  import iop_pkg::*;

  function automatic int port_w(input int p);
    case (p)
      0:       return W_A;
      1:       return W_B;
      2:       return W_C;
      default: return W_D;
    endcase
  endfunction

  function automatic int port_base(input int p);
    int s;
    s = 0;
    for (int q = 0; q < p; q++) s += port_w(q);
    return s;
  endfunction

  logic [NPIN-1:0]        dout_all, dir_all, pl0_all, pl1_all;
  logic [3:0][DW-1:0]     rd_port;
  logic [AW-1:0]          addr_q;
  logic                   ale_fall;

  iop_addr_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst_n(rst_n), .ale(ale), .addr_i(addr_i),
    .addr_q(addr_q), .ale_fall(ale_fall)
  );

  for (genvar p = 0; p < 4; p++) begin : g_port
    localparam int PW   = port_w(p);
    localparam int BASE = port_base(p);

    iop_port_regs #(.W(PW), .DW(DW), .PORT_ID(p)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we),
      .sel_port(reg_addr[3:2]), .sel_kind(reg_addr[1:0]),
      .wdata(reg_wdata), .pad(pin_i[BASE +: PW]),
      .rdata(rd_port[p]),
      .dout_q(dout_all[BASE +: PW]), .dir_q(dir_all[BASE +: PW]),
      .plane0_q(pl0_all[BASE +: PW]), .plane1_q(pl1_all[BASE +: PW])
    );

    for (genvar i = 0; i < PW; i++) begin : g_pin
      localparam int K  = BASE + i;
      localparam int AI = latch_index(p, i, AW);
      localparam bit DP = (p < 2);
      localparam int BI = DP ? K : 0;

      iop_pin_cell #(.HAS_DPORT(DP)) u_cell (
        .mode({pl1_all[K], pl0_all[K]}),
        .sw_dout(dout_all[K]), .sw_dir(dir_all[K]),
        .lg_out(pld_out[K]), .lg_oe(pld_oe[K]),
        .addr_b(addr_q[AI]), .bus_rd(bus_rd), .bus_b(bus_rdata[BI]),
        .pin_o(pin_o[K]), .pin_oe(pin_oe[K])
      );

      // R8: an address-mode pin always drives its latched bit
      a_r8_addr_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (pl1_all[K] && !pl0_all[K]) |-> (pin_oe[K] && pin_o[K] == addr_q[AI]));

      if (DP) begin : g_dp_chk
        // R9: data-port pins float outside a read cycle
        a_r9_dport_float: assert property (@(posedge clk) disable iff (!rst_n)
          (pl1_all[K] && pl0_all[K] && !bus_rd) |-> !pin_oe[K]);
      end else begin : g_sw_chk
        // R10: mode 3 on ports C and D follows the direction bit
        a_r10_mode3_sw: assert property (@(posedge clk) disable iff (!rst_n)
          (pl1_all[K] && pl0_all[K]) |-> (pin_oe[K] == dir_all[K]));
      end
    end
  end

  assign reg_rdata = rd_port[reg_addr[3:2]];
  assign pld_in    = pin_i;
  assign bus_wdata = pin_i[BUS_W-1:0];

  // R2: no pin drives on the first edge after reset
  a_r2_floating: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pin_oe == '0);

endmodule

// File: tb/iop_bank_tb.sv
module iop_bank_tb;

  localparam int NP = 27;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        ale = 1'b0;
  logic [15:0] addr_i = '0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata = '0;
  logic [15:0] bus_wdata;
  logic [NP-1:0] pld_out = '0, pld_oe = '0, pld_in, pin_i = '0, pin_o, pin_oe;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  iop_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ale(ale), .addr_i(addr_i),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_wdata(bus_wdata),
    .pld_out(pld_out), .pld_oe(pld_oe), .pld_in(pld_in),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  // ---------------- reference model ----------------
  bit m_dout[NP], m_dir[NP], m_p0[NP], m_p1[NP];
  bit [15:0] m_latch;
  bit m_ale_prev;

  function automatic int pwidth(input int p);
    return (p == 3) ? 3 : 8;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NP; k++) begin
        m_dout[k] = 0; m_dir[k] = 0; m_p0[k] = 0; m_p1[k] = 0;
      end
      m_latch = '0;
      m_ale_prev = 0;
    end else begin
      if (reg_we) begin
        for (int b = 0; b < pwidth(reg_addr[3:2]); b++) begin
          int k;
          k = reg_addr[3:2] * 8 + b;
          case (reg_addr[1:0])
            2'd0: m_dout[k] = reg_wdata[b];
            2'd1: m_dir[k]  = reg_wdata[b];
            2'd2: m_p0[k]   = reg_wdata[b];
            default: m_p1[k] = reg_wdata[b];
          endcase
        end
      end
      if (m_ale_prev && !ale) m_latch = addr_i;
      m_ale_prev = ale;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic expect_pin(input int k, output bit oe, output bit o, output string tag);
    int p, b, mode;
    p = k / 8; b = k % 8;
    mode = {m_p1[k], m_p0[k]};
    oe = m_dir[k]; o = m_dout[k]; tag = "R5";
    if (mode == 1) begin oe = pld_oe[k]; o = pld_out[k]; tag = "R7"; end
    else if (mode == 2) begin oe = 1; o = m_latch[(p % 2) * 8 + b]; tag = "R8"; end
    else if (mode == 3) begin
      if (p < 2) begin oe = bus_rd; o = bus_rdata[k]; tag = "R9"; end
      else tag = "R10";
    end
  endtask

  function automatic logic [7:0] expect_rd();
    logic [7:0] v;
    int p;
    v = '0;
    p = reg_addr[3:2];
    for (int b = 0; b < pwidth(p); b++) begin
      int k;
      k = p * 8 + b;
      case (reg_addr[1:0])
        2'd0: v[b] = m_dir[k] ? m_dout[k] : pin_i[k];
        2'd1: v[b] = m_dir[k];
        2'd2: v[b] = m_p0[k];
        default: v[b] = m_p1[k];
      endcase
    end
    return v;
  endfunction

  // per-cycle comparison, 2 ns after the falling edge
  always begin
    @(negedge clk);
    #2;
    if (rst_n && !done) begin
      for (int k = 0; k < NP; k++) begin
        bit eo, ev;
        string t;
        expect_pin(k, eo, ev, t);
        chk(t, 32'(pin_oe[k]), 32'(eo));
        if (eo) chk(t, 32'(pin_o[k]), 32'(ev));
      end
      chk((reg_addr[1:0] == 2'd0) ? "R6" : "R3", 32'(reg_rdata), 32'(expect_rd()));
      chk("R7", 32'(pld_in), 32'(pin_i));
      chk("R9", 32'(bus_wdata), 32'(pin_i[15:0]));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int port, input int kind, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(port * 4 + kind); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_sel(input int port, input int kind);
    @(negedge clk);
    reg_addr = 4'(port * 4 + kind);
  endtask

  task automatic strobe(input logic [15:0] a);
    @(negedge clk); ale = 1'b1; addr_i = a;
    @(negedge clk); ale = 1'b0;
    @(negedge clk); addr_i = ~a;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R2 watchdog: actual=timeout expected=finish");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    pin_i = 27'h5A5A5A5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
    // R2: reset state
    chk("R2", 32'(pin_oe), 32'h0);
    rd_sel(1, 1); #3 chk("R2", 32'(reg_rdata), 32'h00);
    rd_sel(0, 0); #3 chk("R6", 32'(reg_rdata), 32'(pin_i[7:0]));

    // R3/R5/R6: port A output value and direction
    wr(0, 0, 8'hA5);
    wr(0, 1, 8'hF0);
    rd_sel(0, 0); #3 chk("R6", 32'(reg_rdata), 32'({4'hA, pin_i[3:0]}));
    chk("R5", 32'(pin_oe[7:0]), 32'hF0);

    // R1/R3: port D is pins 24-26, upper bits ignored
    wr(3, 0, 8'hFD);
    wr(3, 1, 8'hFF);
    #3 chk("R1", 32'(pin_oe[26:24]), 32'h7);
    chk("R1", 32'(pin_o[26:24]), 32'h5);
    rd_sel(3, 1); #3 chk("R3", 32'(reg_rdata), 32'h07);

    // R4: switch only pin 3 of port A into logic mode
    pld_out = 27'h0; pld_oe = 27'h0;
    wr(0, 2, 8'h08);
    #3 chk("R4", 32'(pin_oe[7:0]), 32'hF0);
    pld_oe = 27'h7FFFFFF; pld_out = 27'h0000008;
    #1 chk("R4", 32'(pin_oe[7:0]), 32'hF8);
    chk("R7", 32'(pin_o[3]), 32'h1);
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      pld_out = 27'($urandom); pld_oe = 27'($urandom); pin_i = 27'($urandom);
    end

    // R8: port B and low half of port C in address mode
    wr(1, 3, 8'hFF); wr(1, 2, 8'h00);
    wr(2, 3, 8'h0F); wr(2, 2, 8'h00);
    strobe(16'hC35A);
    #3 chk("R8", 32'(pin_o[15:8]), 32'hC3);
    chk("R8", 32'(pin_o[19:16]), 32'hA);
    @(negedge clk); ale = 1'b1; addr_i = 16'h1234;
    #3 chk("R8", 32'(pin_o[15:8]), 32'hC3);
    @(negedge clk); ale = 1'b0;
    #3 chk("R8", 32'(pin_o[15:8]), 32'hC3);
    @(negedge clk); addr_i = 16'hFFFF;
    #3 chk("R8", 32'(pin_o[15:8]), 32'h12);
    for (int n = 0; n < 10; n++) strobe(16'($urandom));

    // R9: ports A and B as the data bus
    wr(0, 2, 8'hFF); wr(0, 3, 8'hFF);
    wr(1, 2, 8'hFF); wr(1, 3, 8'hFF);
    @(negedge clk); bus_rd = 1'b0; bus_rdata = 16'hBEEF;
    #3 chk("R9", 32'(pin_oe[15:0]), 32'h0);
    @(negedge clk); bus_rd = 1'b1;
    #3 chk("R9", 32'(pin_o[15:0]), 32'hBEEF);
    chk("R9", 32'(pin_oe[15:0]), 32'hFFFF);
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      bus_rd = 1'($urandom); bus_rdata = 16'($urandom); pin_i = 27'($urandom);
    end

    // R10: mode 3 on ports C and D behaves as software I/O
    wr(2, 0, 8'h3C); wr(2, 1, 8'h0F);
    wr(2, 2, 8'hFF); wr(2, 3, 8'hFF);
    wr(3, 2, 8'hFF); wr(3, 3, 8'hFF);
    @(negedge clk); bus_rd = 1'b1;
    #3 chk("R10", 32'(pin_oe[23:16]), 32'h0F);
    chk("R10", 32'(pin_o[19:16]), 32'hC);

    // mixed traffic, checked every cycle by the model
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      reg_we = 1'($urandom % 4 == 0);
      reg_addr = 4'($urandom); reg_wdata = 8'($urandom);
      ale = 1'($urandom); addr_i = 16'($urandom);
      bus_rd = 1'($urandom); bus_rdata = 16'($urandom);
      pld_out = 27'($urandom); pld_oe = 27'($urandom); pin_i = 27'($urandom);
    end
    @(negedge clk); reg_we = 1'b0;
    repeat (2) @(negedge clk);
    #4;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule